// File: doc/BRIEF.md
# Four-Operand Low-Toggle Adder

This block adds four unsigned operands and returns their full-precision sum, arranged so that the adder logic switches as little as possible. Each operand goes through its own capture register, so all four adder inputs change on the same clock edge. The sum is built as a balanced tree. Two pairwise additions run in parallel, and a pipeline register sits between them and the final addition, which keeps each stage shallow.

A result multiplexer picks either the sum or a separate bypass operand for each accepted sample. The same select signal that steers this multiplexer also gates the load enables of the operand registers and the pairwise-sum registers. While the bypass path is in use, the adder inputs therefore stay frozen and the arithmetic does not toggle. The bypass value travels in its own register chain, which is enabled only for bypass samples, so both kinds of result arrive with the same latency.

A sample is accepted on a rising edge where the valid input is high. Its result and the valid output appear after the second rising edge that follows the capture edge. The result register holds its value between valid outputs.

Top module: `add4_tree`

## Requirements
- R1: For an accepted sample with the select low (sum mode), the result equals A+B+C+D, computed at a width of W+2 bits.
- R2: The valid output is high after a rising edge exactly when the valid input was high two edges earlier, counting from the capture edge. That gives one output for every accepted sample, with fixed latency.
- R3: For an accepted sample with the select high (bypass mode), the result equals the bypass operand zero-extended to W+2 bits.
- R4: Sum and bypass samples may be interleaved in any order, one per cycle. Each result matches its own sample, and operands held during bypass samples never leak into a later result.
- R5: While the valid output is low, the result keeps the value of the most recent valid output.
- R6: A synchronous reset (active high) clears the result to zero and drops the valid output on the next edge, discarding any samples in flight.
- R7: With all four operands at their maximum value 2^W-1, the result is 4*(2^W-1), so no carry is lost in either adder stage.
- R8: Operand, bypass and select inputs presented while the valid input is low have no effect on any later output.
- R9: Sums accepted on consecutive cycles produce results on consecutive cycles, one per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| validIn | input | 1 | Sample accepted on this edge |
| selBypass | input | 1 | 1 = return the bypass operand, 0 = return the sum |
| opA | input | W | Operand A |
| opB | input | W | Operand B |
| opC | input | W | Operand C |
| opD | input | W | Operand D |
| bypassIn | input | W | Bypass operand |
| validOut | output | 1 | Result is new on this cycle |
| result | output | W+2 | Sum or zero-extended bypass operand |

## Verification
A sample driven before rising edge k produces its result and its valid output after edge k+2, whether it is a sum or a bypass. A reset applied before edge k shows up after edge k itself. The bench keeps a three-deep model pipeline that shifts right after every rising edge, with its entries computed from the requirements, and it compares the outputs 1 ns after that edge against the model's last stage. This way every check lands in exactly the cycle the latency rule names. Random traffic mixes sum, bypass and idle cycles, while directed runs cover all-ones operands, alternating modes, gaps with garbage inputs and a reset in the middle of traffic.

// File: rtl/add4_pkg.sv
package add4_pkg;

  // Strobes sent from the control to the datapath
  typedef struct packed {
    logic opLoad;     // capture the four operands (sum sample accepted)
    logic bypLoad;    // capture the bypass operand (bypass sample accepted)
    logic pairLoad;   // register the two pairwise sums
    logic byp2Load;   // advance the bypass operand one stage
    logic outLoad;    // update the result register
    logic outSelSum;  // 1: result takes the final sum, 0: the bypass value
  } ctrlStrobe_t;

  localparam int NUM_OPS   = 4;
  localparam int NUM_PAIRS = NUM_OPS / 2;

endpackage

// File: rtl/add4_ctrl.sv
module add4_ctrl
  import add4_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        validIn,
  input  logic        selBypass,
  output ctrlStrobe_t strb,
  output logic        validOut
);

  logic stg1Valid, stg1Byp;
  logic stg2Valid, stg2Byp;
  logic outValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg1Valid <= 1'b0;
      stg1Byp   <= 1'b0;
      stg2Valid <= 1'b0;
      stg2Byp   <= 1'b0;
      outValid  <= 1'b0;
    end else begin
      stg1Valid <= validIn;
      stg1Byp   <= validIn & selBypass;
      stg2Valid <= stg1Valid;
      stg2Byp   <= stg1Byp;
      outValid  <= stg2Valid;
    end
  end

  // The select gates every adder-side enable: operand isolation
  always_comb begin
    strb.opLoad    = validIn & ~selBypass;
    strb.bypLoad   = validIn & selBypass;
    strb.pairLoad  = stg1Valid & ~stg1Byp;
    strb.byp2Load  = stg1Valid & stg1Byp;
    strb.outLoad   = stg2Valid;
    strb.outSelSum = ~stg2Byp;
  end

  assign validOut = outValid;

  AST_LOAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.opLoad, strb.bypLoad})) else $error("sum and bypass capture together"); // R3

  AST_STAGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.pairLoad, strb.byp2Load})) else $error("pair and bypass stage together"); // R4

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!validOut && !stg1Valid && !stg2Valid)) else $error("reset did not clear valids"); // R6

  AST_VALID_CHAIN: assert property (@(posedge clk) disable iff (rst)
    stg1Valid |=> strb.outLoad) else $error("stage valid lost"); // R2

endmodule

// File: rtl/add4_datapath.sv
module add4_datapath
  import add4_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  ctrlStrobe_t               strb,
  input  logic [NUM_OPS-1:0][W-1:0] opIn,
  input  logic [W-1:0]              bypassIn,
  output logic [W+1:0]              result
);

  localparam int PW = W + 1;   // pairwise sum width
  localparam int RW = W + 2;   // final sum width

  logic [NUM_OPS-1:0][W-1:0]    opReg;
  logic [NUM_PAIRS-1:0][PW-1:0] pairReg;
  logic [W-1:0]                 byp1, byp2;
  logic [RW-1:0]                finalSum;
  logic [RW-1:0]                resReg;

  // Operand capture: one register per operand, enabled only for sum samples
  for (genvar i = 0; i < NUM_OPS; i++) begin : gOpReg
    always_ff @(posedge clk) begin
      if (rst)              opReg[i] <= '0;
      else if (strb.opLoad) opReg[i] <= opIn[i];
    end
  end

  // First tree level: pairwise sums, frozen while the bypass path is used
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : gPair
    always_ff @(posedge clk) begin
      if (rst)                pairReg[p] <= '0;
      else if (strb.pairLoad) pairReg[p] <= PW'(opReg[2*p]) + PW'(opReg[2*p+1]);
    end
  end

  // Second tree level
  assign finalSum = RW'(pairReg[0]) + RW'(pairReg[1]);

  // Bypass operand chain, matched to the adder latency
  always_ff @(posedge clk) begin
    if (rst) begin
      byp1 <= '0;
      byp2 <= '0;
    end else begin
      if (strb.bypLoad)  byp1 <= bypassIn;
      if (strb.byp2Load) byp2 <= byp1;
    end
  end

  // Result multiplexer and register
  always_ff @(posedge clk) begin
    if (rst)                resReg <= '0;
    else if (strb.outLoad)  resReg <= strb.outSelSum ? finalSum : RW'(byp2);
  end

  assign result = resReg;

  AST_OPS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !strb.opLoad |=> $stable(opReg)) else $error("operands moved while isolated"); // R4

  AST_PAIRS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !strb.pairLoad |=> $stable(pairReg)) else $error("pair sums moved while isolated"); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (finalSum >= RW'(pairReg[0])) && (finalSum >= RW'(pairReg[1]))) else $error("carry lost"); // R7

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strb.outLoad |=> $stable(result)) else $error("result changed without valid"); // R5

endmodule

// File: rtl/add4_tree.sv
module add4_tree
  import add4_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         validIn,
  input  logic         selBypass,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] opC,
  input  logic [W-1:0] opD,
  input  logic [W-1:0] bypassIn,
  output logic         validOut,
  output logic [W+1:0] result
);

  ctrlStrobe_t               strb;
  logic [NUM_OPS-1:0][W-1:0] opBus;

  assign opBus = {opD, opC, opB, opA};

  add4_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .validIn  (validIn),
    .selBypass(selBypass),
    .strb     (strb),
    .validOut (validOut)
  );

  add4_datapath #(.W(W)) uData (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .opIn    (opBus),
    .bypassIn(bypassIn),
    .result  (result)
  );

endmodule

// File: tb/sim_add4_tree.sv
module sim_add4_tree;

  localparam int W  = 16;
  localparam int RW = W + 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic          rst = 1'b1;
  logic          validIn = 1'b0, selBypass = 1'b0;
  logic [W-1:0]  opA = '0, opB = '0, opC = '0, opD = '0, bypassIn = '0;
  logic          validOut;
  logic [RW-1:0] result;

  add4_tree #(.W(W)) u0 (
    .clk(clk), .rst(rst), .validIn(validIn), .selBypass(selBypass),
    .opA(opA), .opB(opB), .opC(opC), .opD(opD), .bypassIn(bypassIn),
    .validOut(validOut), .result(result)
  );

  int nChecks = 0, nErrors = 0;
  bit finished = 0;
  string phase = "reset";

  // Reference pipeline built from the requirements
  bit            mValid [3] = '{0, 0, 0};
  bit            mByp   [3] = '{0, 0, 0};
  logic [RW-1:0] mVal   [3] = '{'0, '0, '0};
  logic [RW-1:0] expRes = '0;

  function automatic logic [RW-1:0] refSum(logic [W-1:0] a, b, c, d);
    return RW'(a) + RW'(b) + RW'(c) + RW'(d);
  endfunction

  task automatic check(string req, logic [RW-1:0] act, logic [RW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s [%s] t=%0t actual=%h expected=%h", req, phase, $time, act, exp);
    end
  endtask

  task automatic cycle(bit v, bit s, logic [W-1:0] a, b, c, d, byp);
    string tag;
    @(negedge clk);
    validIn = v; selBypass = s;
    opA = a; opB = b; opC = c; opD = d; bypassIn = byp;
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < 3; i++) begin mValid[i] = 0; mByp[i] = 0; mVal[i] = '0; end
      expRes = '0;
    end else begin
      for (int i = 2; i > 0; i--) begin
        mValid[i] = mValid[i-1]; mByp[i] = mByp[i-1]; mVal[i] = mVal[i-1];
      end
      mValid[0] = v; mByp[0] = s;
      mVal[0]   = s ? RW'(byp) : refSum(a, b, c, d);
      if (mValid[2]) expRes = mVal[2];
    end
    #1;
    if (rst) tag = "R6";
    else if (!mValid[2]) tag = "R5";
    else tag = mByp[2] ? "R3" : "R1";
    check(rst ? "R6" : "R2", RW'(validOut), RW'(mValid[2]));
    check(tag, result, expRes);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle(0, 0, '0, '0, '0, '0, '0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nErrors++;
      $display("FAIL watchdog [%s] actual=timeout expected=completion", phase);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R6: reset state
    rst = 1'b1;
    idle(3);
    rst = 1'b0;

    phase = "R1 directed";
    cycle(1, 0, 16'd1, 16'd2, 16'd3, 16'd4, 16'hFFFF);
    idle(3);

    phase = "R7 all ones";
    cycle(1, 0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, '0);
    idle(3);

    phase = "R3 directed";
    cycle(1, 1, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'hBEEF);
    idle(3);

    phase = "R4 alternating";
    for (int i = 0; i < 8; i++)
      cycle(1, i[0], 16'(i * 7 + 1), 16'hF000, 16'(i), 16'h0F0F, 16'(16'hA000 + i));
    idle(3);

    phase = "R9 back to back";
    for (int i = 0; i < 10; i++)
      cycle(1, 0, 16'(i * 4099), 16'(16'hFFFF - i), 16'(i * 3), 16'h8000, '0);
    idle(3);

    phase = "R8 ignored inputs";
    cycle(1, 0, 16'd10, 16'd20, 16'd30, 16'd40, '0);
    for (int i = 0; i < 6; i++)
      cycle(0, i[0], 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
    idle(2);

    phase = "random";
    for (int i = 0; i < 3000; i++)
      cycle(($urandom % 4) != 0, ($urandom % 3) == 0,
            16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));

    phase = "R6 mid-run reset";
    cycle(1, 0, 16'd5, 16'd6, 16'd7, 16'd8, '0);
    cycle(1, 1, '0, '0, '0, '0, 16'h1234);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(4);

    finished = 1;
    finish_run();
  end

endmodule